// File: doc/BRIEF.md
# Fetch Program Counter Generator with Delayed Branch

This block owns the fetch-stage program counter of a five-stage 32-bit RISC pipeline and chooses, every cycle, the address the PC register loads at the next clock edge. Conditional branches and jumps are resolved one stage after fetch, in the register-read stage. The sole branch condition is a zero test on the forwarded register operand. Because the decision lags fetch by one cycle, the instruction fetched while the branch is being resolved (the delay slot) is always executed and is never cancelled. The redirect only takes effect on the fetch after it.

The candidate addresses are as follows. The sequential address is the fetch PC plus four. The PC-relative branch target is formed from the branching instruction's own address plus four. The absolute jump target takes its top bits from the branching instruction's address. The register target is the forwarded operand. Three fixed vectors cover a machine restart, an undefined instruction and an interrupt. A stall input freezes the PC. A synchronous restart (the reset pin or a restart request) overrides everything, including the stall. The block reports the address it will load next and a flag saying that a branch or jump redirect was chosen.

Top module: `npc_select`

## Requirements
- R1: While `rst_n` is low at a clock edge, `fetch_pc` loads 0x80000000 at that edge, even if `stall` is high; `next_pc` shows 0x80000000 and `taken` is 0 during that cycle.
- R2: With `flow` = 0 (sequential), no event and no stall, `next_pc` equals `fetch_pc` + 4, `taken` is 0, and `fetch_pc` takes that value at the next edge.
- R3: With `flow` = 1 (branch if zero), the branch is taken only when `rr_opnd` is zero, and `flow` = 2 (branch if nonzero) only when it is nonzero. A taken branch gives `next_pc` = `rr_pc` + 4 + (sign-extended `br_off` × 4) with `taken` = 1. A branch that is not taken gives `fetch_pc` + 4 with `taken` = 0.
- R4: `br_off` is a signed 16-bit word offset: bit 15 set gives a backward target below `rr_pc` + 4.
- R5: With `flow` = 3 (jump), `next_pc` has bits 31:29 equal to `rr_pc` bits 31:29, bit 28 zero, bits 27:2 equal to `jmp_field`, and bits 1:0 zero; `taken` = 1.
- R6: With `flow` = 4 (register jump), `next_pc` equals the forwarded operand `rr_opnd` unchanged; `taken` = 1.
- R7: `ill_op` high, or a `flow` code of 5, 6 or 7, selects 0x80000040 with `taken` = 0.
- R8: `irq` high selects 0x80000080 with `taken` = 0, and wins over `ill_op` and over any `flow` code.
- R9: `soft_rst` high selects 0x80000000 with `taken` = 0, and wins over `irq`, `ill_op`, `flow` and `stall`.
- R10: With `stall` high and no restart, `fetch_pc` keeps its value, `next_pc` equals `fetch_pc` and `taken` is 0. Any branch, jump, `irq` or `ill_op` presented in that cycle has no effect.
- R11: A redirect never cancels the delay slot. In the cycle `taken` is high, `fetch_pc` is still the sequential successor of the branch (`rr_pc` + 4). The target appears in `fetch_pc` only at the following edge, and sequential fetch continues from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stall | input | 1 | Freeze the fetch PC this cycle |
| soft_rst | input | 1 | Restart request, forces the reset vector |
| irq | input | 1 | Interrupt request, forces the interrupt vector |
| ill_op | input | 1 | Undefined instruction in register-read stage |
| flow | input | 3 | Flow class of the register-read instruction: 0 sequential, 1 branch-if-zero, 2 branch-if-nonzero, 3 jump, 4 register jump |
| rr_pc | input | 32 | Address of the instruction in register-read stage |
| br_off | input | 16 | Branch word offset, signed |
| jmp_field | input | 26 | Absolute jump field |
| rr_opnd | input | 32 | Forwarded register operand (zero test and register target) |
| fetch_pc | output | 32 | Current fetch address |
| next_pc | output | 32 | Address loaded at the next edge |
| taken | output | 1 | Branch or jump redirect selected this cycle |

## Verification
Several sources can compete in one cycle: a taken branch with an interrupt, an interrupt with an undefined instruction, and any redirect with a stall or a restart. The bench provokes each of these by driving the competing inputs together on one falling edge. It judges the result from `next_pc` and `taken` in that cycle and from `fetch_pc` after the edge, against the priority order in R8, R9 and R10. The delay slot is judged across two cycles, by checking that `fetch_pc` keeps the slot address while `taken` is high.

// File: rtl/npc_pkg.sv
// Package: shared encodings for the fetch PC generator.
// Assumes: 3-bit flow classes from decode; select codes fixed as below.
package npc_pkg;

    // Flow class of the instruction in the register-read stage.
    typedef enum logic [2:0] {
        FLOW_SEQ  = 3'd0,
        FLOW_BZ   = 3'd1,
        FLOW_BNZ  = 3'd2,
        FLOW_JMP  = 3'd3,
        FLOW_JREG = 3'd4
    } flow_e;

    // PC source select codes.
    typedef enum logic [2:0] {
        SEL_SEQ  = 3'd0,
        SEL_BR   = 3'd1,
        SEL_JMP  = 3'd2,
        SEL_REG  = 3'd3,
        SEL_ILL  = 3'd4,
        SEL_IRQ  = 3'd5,
        SEL_RST  = 3'd6
    } pc_sel_e;

    localparam int N_PC_SRC = 7;

endpackage

// File: rtl/npc_targets.sv
// Module: npc_targets
// Computes the three redirect targets and the zero test for the
// instruction in register-read stage.
// Assumes: rr_opnd already carries the forwarded value; the branch base
// is the branching instruction's address plus one word.
module npc_targets #(
    parameter int XLEN    = 32,
    parameter int OFF_W   = 16,
    parameter int JF_W    = 26,
    parameter int PC_KEEP = 3
) (
    input  logic [XLEN-1:0]  rr_pc,
    input  logic [OFF_W-1:0] br_off,
    input  logic [JF_W-1:0]  jmp_field,
    input  logic [XLEN-1:0]  rr_opnd,
    output logic [XLEN-1:0]  br_tgt,
    output logic [XLEN-1:0]  jmp_tgt,
    output logic [XLEN-1:0]  reg_tgt,
    output logic             opnd_zero
);

    localparam int EXT_W = XLEN - OFF_W - 2;
    localparam int GAP_W = XLEN - PC_KEEP - JF_W - 2;

    logic [XLEN-1:0] off_bytes;
    logic [XLEN-1:0] br_base;

    // Word offset, sign-extended and scaled to bytes.
    assign off_bytes = {{EXT_W{br_off[OFF_W-1]}}, br_off, 2'b00};

    // Base address: the delay-slot address.
    assign br_base = rr_pc + XLEN'(4);

    // Branch target adder.
    assign br_tgt = br_base + off_bytes;

    // Absolute jump target; any bits between kept PC bits and field are zero.
    generate
        if (GAP_W > 0) begin : g_gap
            assign jmp_tgt = {rr_pc[XLEN-1 -: PC_KEEP], {GAP_W{1'b0}}, jmp_field, 2'b00};
        end else begin : g_nogap
            assign jmp_tgt = {rr_pc[XLEN-1 -: PC_KEEP], jmp_field, 2'b00};
        end
    endgenerate

    // Register target comes straight from the forwarded operand.
    assign reg_tgt = rr_opnd;

    // Branch condition: zero test of the forwarded operand.
    assign opnd_zero = (rr_opnd == '0);

endmodule

// File: rtl/npc_decide.sv
// Module: npc_decide
// Chooses the PC source, the load enable and the taken flag.
// Priority: restart (pin or request) > stall > interrupt > undefined
// instruction > flow class. Unknown flow codes count as undefined.
// Assumes: purely combinational; the PC register lives in the top.
module npc_decide
    import npc_pkg::*;
(
    input  logic       rst_n,
    input  logic       soft_rst,
    input  logic       stall,
    input  logic       irq,
    input  logic       ill_op,
    input  logic [2:0] flow,
    input  logic       opnd_zero,
    output pc_sel_e    sel,
    output logic       load,
    output logic       taken
);

    flow_e flow_c;

    // Typed view of the incoming flow class.
    assign flow_c = flow_e'(flow);

    // Priority selection of the next PC source.
    always_comb begin
        sel   = SEL_SEQ;
        load  = 1'b1;
        taken = 1'b0;
        if (!rst_n || soft_rst) begin
            sel = SEL_RST;
        end else if (stall) begin
            load = 1'b0;
        end else if (irq) begin
            sel = SEL_IRQ;
        end else if (ill_op) begin
            sel = SEL_ILL;
        end else begin
            case (flow_c)
                FLOW_SEQ: sel = SEL_SEQ;
                FLOW_BZ: begin
                    if (opnd_zero) begin
                        sel   = SEL_BR;
                        taken = 1'b1;
                    end
                end
                FLOW_BNZ: begin
                    if (!opnd_zero) begin
                        sel   = SEL_BR;
                        taken = 1'b1;
                    end
                end
                FLOW_JMP: begin
                    sel   = SEL_JMP;
                    taken = 1'b1;
                end
                FLOW_JREG: begin
                    sel   = SEL_REG;
                    taken = 1'b1;
                end
                default: sel = SEL_ILL;
            endcase
        end
    end

endmodule

// File: rtl/npc_mux.sv
// Module: npc_mux
// AND-OR multiplexer over the seven PC sources, indexed by select code.
// Assumes: sel holds a defined code; an undefined code yields zero.
module npc_mux
    import npc_pkg::*;
#(
    parameter int XLEN = 32,
    parameter logic [XLEN-1:0] RST_VEC = 32'h8000_0000,
    parameter logic [XLEN-1:0] ILL_VEC = 32'h8000_0040,
    parameter logic [XLEN-1:0] IRQ_VEC = 32'h8000_0080
) (
    input  pc_sel_e         sel,
    input  logic [XLEN-1:0] seq_pc,
    input  logic [XLEN-1:0] br_tgt,
    input  logic [XLEN-1:0] jmp_tgt,
    input  logic [XLEN-1:0] reg_tgt,
    output logic [XLEN-1:0] pc_out
);

    logic [XLEN-1:0] src  [N_PC_SRC];
    logic [XLEN-1:0] gated[N_PC_SRC];

    // Source table in select-code order.
    assign src[SEL_SEQ] = seq_pc;
    assign src[SEL_BR]  = br_tgt;
    assign src[SEL_JMP] = jmp_tgt;
    assign src[SEL_REG] = reg_tgt;
    assign src[SEL_ILL] = ILL_VEC;
    assign src[SEL_IRQ] = IRQ_VEC;
    assign src[SEL_RST] = RST_VEC;

    // One gate per source, enabled by its select code.
    generate
        for (genvar i = 0; i < N_PC_SRC; i++) begin : g_gate
            assign gated[i] = (sel == pc_sel_e'(i)) ? src[i] : '0;
        end
    endgenerate

    // OR-reduce the gated sources.
    always_comb begin
        pc_out = '0;
        for (int i = 0; i < N_PC_SRC; i++) begin
            pc_out = pc_out | gated[i];
        end
    end

endmodule

// File: rtl/npc_select.sv
// Module: npc_select (top)
// Holds the fetch PC and loads the next one each cycle from the
// sequential, branch, jump, register or vector source. Redirects are
// decided in register-read stage, so the delay slot is always fetched.
// Assumes: synchronous active-low reset; inputs settle within the cycle.
module npc_select
    import npc_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int OFF_W   = 16,
    parameter int JF_W    = 26,
    parameter int PC_KEEP = 3,
    parameter logic [XLEN-1:0] RST_VEC = 32'h8000_0000,
    parameter logic [XLEN-1:0] ILL_VEC = 32'h8000_0040,
    parameter logic [XLEN-1:0] IRQ_VEC = 32'h8000_0080
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stall,
    input  logic             soft_rst,
    input  logic             irq,
    input  logic             ill_op,
    input  logic [2:0]       flow,
    input  logic [XLEN-1:0]  rr_pc,
    input  logic [OFF_W-1:0] br_off,
    input  logic [JF_W-1:0]  jmp_field,
    input  logic [XLEN-1:0]  rr_opnd,
    output logic [XLEN-1:0]  fetch_pc,
    output logic [XLEN-1:0]  next_pc,
    output logic             taken
);

    logic [XLEN-1:0] pc_q;
    logic [XLEN-1:0] seq_pc;
    logic [XLEN-1:0] br_tgt;
    logic [XLEN-1:0] jmp_tgt;
    logic [XLEN-1:0] reg_tgt;
    logic [XLEN-1:0] mux_pc;
    logic            opnd_zero;
    logic            load;
    pc_sel_e         sel;

    // Sequential successor of the current fetch address.
    assign seq_pc = pc_q + XLEN'(4);

    npc_targets #(
        .XLEN    (XLEN),
        .OFF_W   (OFF_W),
        .JF_W    (JF_W),
        .PC_KEEP (PC_KEEP)
    ) u_tgt (
        .rr_pc     (rr_pc),
        .br_off    (br_off),
        .jmp_field (jmp_field),
        .rr_opnd   (rr_opnd),
        .br_tgt    (br_tgt),
        .jmp_tgt   (jmp_tgt),
        .reg_tgt   (reg_tgt),
        .opnd_zero (opnd_zero)
    );

    npc_decide u_dec (
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .stall     (stall),
        .irq       (irq),
        .ill_op    (ill_op),
        .flow      (flow),
        .opnd_zero (opnd_zero),
        .sel       (sel),
        .load      (load),
        .taken     (taken)
    );

    npc_mux #(
        .XLEN    (XLEN),
        .RST_VEC (RST_VEC),
        .ILL_VEC (ILL_VEC),
        .IRQ_VEC (IRQ_VEC)
    ) u_mux (
        .sel     (sel),
        .seq_pc  (seq_pc),
        .br_tgt  (br_tgt),
        .jmp_tgt (jmp_tgt),
        .reg_tgt (reg_tgt),
        .pc_out  (mux_pc)
    );

    // Value the PC register takes at the next edge.
    assign next_pc = load ? mux_pc : pc_q;

    // Fetch PC register with synchronous reset and stall hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= RST_VEC;
        end else if (load) begin
            pc_q <= mux_pc;
        end
    end

    assign fetch_pc = pc_q;

endmodule

// File: rtl/npc_select_chk.sv
// Module: npc_select_chk
// Temporal checks on the fetch PC generator, bound to the top.
// Assumes: the same parameter values as the instance it watches.
module npc_select_chk #(
    parameter int XLEN    = 32,
    parameter int JF_W    = 26,
    parameter int PC_KEEP = 3,
    parameter logic [XLEN-1:0] RST_VEC = 32'h8000_0000,
    parameter logic [XLEN-1:0] ILL_VEC = 32'h8000_0040,
    parameter logic [XLEN-1:0] IRQ_VEC = 32'h8000_0080
) (
    input logic            clk,
    input logic            rst_n,
    input logic            stall,
    input logic            soft_rst,
    input logic            irq,
    input logic            ill_op,
    input logic [2:0]      flow,
    input logic [XLEN-1:0] rr_pc,
    input logic [XLEN-1:0] fetch_pc,
    input logic            taken
);

    logic quiet;

    // No restart, stall or trap this cycle.
    assign quiet = !soft_rst && !stall && !irq && !ill_op;

    // R1
    rst_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> fetch_pc == RST_VEC);

    // R2
    seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && flow == 3'd0) |=> fetch_pc == $past(fetch_pc) + XLEN'(4));

    // R5
    jump_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && flow == 3'd3) |=> (fetch_pc[1:0] == 2'b00 &&
            fetch_pc[XLEN-1 -: PC_KEEP] == $past(rr_pc[XLEN-1 -: PC_KEEP])));

    // R7
    ill_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_rst && !stall && !irq && ill_op) |=> fetch_pc == ILL_VEC);

    // R8
    irq_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_rst && !stall && irq) |=> fetch_pc == IRQ_VEC);

    // R9
    soft_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> fetch_pc == RST_VEC);

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !soft_rst) |=> $stable(fetch_pc));

    // R10
    stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> !taken);

    // R8
    trap_no_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq || ill_op || soft_rst) |-> !taken);

endmodule

bind npc_select npc_select_chk #(
    .XLEN    (XLEN),
    .JF_W    (JF_W),
    .PC_KEEP (PC_KEEP),
    .RST_VEC (RST_VEC),
    .ILL_VEC (ILL_VEC),
    .IRQ_VEC (IRQ_VEC)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .stall    (stall),
    .soft_rst (soft_rst),
    .irq      (irq),
    .ill_op   (ill_op),
    .flow     (flow),
    .rr_pc    (rr_pc),
    .fetch_pc (fetch_pc),
    .taken    (taken)
);

// File: tb/sim_npc_select.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected results, the monitor
// pops and compares them 1 ns after each falling edge.
module sim_npc_select;

    localparam logic [31:0] RV = 32'h8000_0000;
    localparam logic [31:0] IV = 32'h8000_0040;
    localparam logic [31:0] QV = 32'h8000_0080;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stall = 1'b0;
    logic        soft_rst = 1'b0;
    logic        irq = 1'b0;
    logic        ill_op = 1'b0;
    logic [2:0]  flow = 3'd0;
    logic [31:0] rr_pc = '0;
    logic [15:0] br_off = '0;
    logic [25:0] jmp_field = '0;
    logic [31:0] rr_opnd = '0;
    logic [31:0] fetch_pc;
    logic [31:0] next_pc;
    logic        taken;

    typedef struct {
        bit          chk_pc;
        logic [31:0] exp_pc;
        logic [31:0] exp_next;
        logic        exp_taken;
        string       req;
    } item_t;

    item_t       sb[$];
    int          n_checks = 0;
    int          n_errors = 0;
    logic [31:0] model_pc = '0;
    bit          pc_known = 1'b0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    npc_select u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .stall     (stall),
        .soft_rst  (soft_rst),
        .irq       (irq),
        .ill_op    (ill_op),
        .flow      (flow),
        .rr_pc     (rr_pc),
        .br_off    (br_off),
        .jmp_field (jmp_field),
        .rr_opnd   (rr_opnd),
        .fetch_pc  (fetch_pc),
        .next_pc   (next_pc),
        .taken     (taken)
    );

    // Drive one cycle of stimulus and push its expected outcome.
    task automatic step(input logic r, input logic sr, input logic st,
                        input logic iq, input logic il, input logic [2:0] fl,
                        input logic [31:0] rp, input logic [15:0] off,
                        input logic [25:0] jf, input logic [31:0] op,
                        input string req);
        item_t       it;
        logic [31:0] nx;
        logic        tk;
        @(negedge clk);
        rst_n = r; soft_rst = sr; stall = st; irq = iq; ill_op = il;
        flow = fl; rr_pc = rp; br_off = off; jmp_field = jf; rr_opnd = op;
        tk = 1'b0;
        if (!r || sr)     nx = RV;
        else if (st)      nx = model_pc;
        else if (iq)      nx = QV;
        else if (il)      nx = IV;
        else begin
            case (fl)
                3'd0: nx = model_pc + 32'd4;
                3'd1: begin tk = (op == 0);
                      nx = tk ? rp + 32'd4 + {{14{off[15]}}, off, 2'b00} : model_pc + 32'd4; end
                3'd2: begin tk = (op != 0);
                      nx = tk ? rp + 32'd4 + {{14{off[15]}}, off, 2'b00} : model_pc + 32'd4; end
                3'd3: begin tk = 1'b1; nx = {rp[31:29], 1'b0, jf, 2'b00}; end
                3'd4: begin tk = 1'b1; nx = op; end
                default: nx = IV;
            endcase
        end
        it.chk_pc = pc_known; it.exp_pc = model_pc;
        it.exp_next = nx; it.exp_taken = tk; it.req = req;
        sb.push_back(it);
        model_pc = nx;
        pc_known = 1'b1;
    endtask

    // Monitor: compare outputs with the oldest expected item.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                if (it.chk_pc) begin
                    n_checks++;
                    if (fetch_pc !== it.exp_pc) begin
                        n_errors++;
                        $display("FAIL %s fetch_pc actual %h expected %h", it.req, fetch_pc, it.exp_pc);
                    end
                end
                n_checks++;
                if (next_pc !== it.exp_next) begin
                    n_errors++;
                    $display("FAIL %s next_pc actual %h expected %h", it.req, next_pc, it.exp_next);
                end
                n_checks++;
                if (taken !== it.exp_taken) begin
                    n_errors++;
                    $display("FAIL %s taken actual %b expected %b", it.req, taken, it.exp_taken);
                end
            end
        end
    end

    // Stimulus sequence.
    initial begin
        // R1: reset wins over stall
        step(0, 0, 1, 0, 0, 3'd0, '0, '0, '0, 32'h1, "R1");
        step(0, 0, 0, 1, 1, 3'd3, '0, '0, '0, 32'h1, "R1");
        // R2: sequential stepping
        step(1, 0, 0, 0, 0, 3'd0, '0, '0, '0, 32'h1, "R2");
        step(1, 0, 0, 0, 0, 3'd0, '0, '0, '0, 32'h1, "R2");
        // R3/R11: beqz taken, branch at 0x80000004, slot 0x80000008 in fetch
        step(1, 0, 0, 0, 0, 3'd1, 32'h8000_0004, 16'h0010, '0, 32'h0, "R3_R11");
        // R11: sequential fetch continues from the target
        step(1, 0, 0, 0, 0, 3'd0, '0, '0, '0, 32'h1, "R11");
        // R3: beqz not taken on nonzero operand
        step(1, 0, 0, 0, 0, 3'd1, 32'h8000_0048, 16'h0010, '0, 32'h7, "R3");
        // R3/R4: bnez taken backwards
        step(1, 0, 0, 0, 0, 3'd2, 32'h8000_0050, 16'hFFFC, '0, 32'h5, "R4");
        // R3: bnez not taken on zero operand
        step(1, 0, 0, 0, 0, 3'd2, 32'h8000_0050, 16'h8000, '0, 32'h0, "R3");
        // R4: most negative offset
        step(1, 0, 0, 0, 0, 3'd1, 32'h8004_0000, 16'h8000, '0, 32'h0, "R4");
        // R5: jump keeps top three bits, bit 28 zero
        step(1, 0, 0, 0, 0, 3'd3, 32'hB000_1234, '0, 26'h3AB_CDEF, 32'h1, "R5");
        step(1, 0, 0, 0, 0, 3'd3, 32'h7FFF_FFFC, '0, 26'h3FF_FFFF, 32'h1, "R5");
        // R6: register jump
        step(1, 0, 0, 0, 0, 3'd4, 32'h8000_0000, '0, '0, 32'h1234_5678, "R6");
        // R10: stall blocks a taken branch, a jump and traps
        step(1, 0, 1, 0, 0, 3'd1, 32'h8000_0000, 16'h0100, '0, 32'h0, "R10");
        step(1, 0, 1, 1, 1, 3'd3, 32'h8000_0000, '0, 26'h1, 32'h0, "R10");
        step(1, 0, 0, 0, 0, 3'd0, '0, '0, '0, 32'h1, "R10");
        // R7: undefined instruction and undefined flow codes
        step(1, 0, 0, 0, 1, 3'd4, '0, '0, '0, 32'h1, "R7");
        step(1, 0, 0, 0, 0, 3'd0, '0, '0, '0, 32'h1, "R2");
        step(1, 0, 0, 0, 0, 3'd6, '0, '0, '0, 32'h1, "R7");
        step(1, 0, 0, 0, 0, 3'd7, '0, '0, '0, 32'h1, "R7");
        // R8: interrupt over undefined and a taken branch
        step(1, 0, 0, 1, 1, 3'd1, 32'h8000_0100, 16'h0004, '0, 32'h0, "R8");
        step(1, 0, 0, 1, 0, 3'd4, '0, '0, '0, 32'h0000_4000, "R8");
        // R9: restart request over interrupt, undefined and stall
        step(1, 1, 1, 1, 1, 3'd3, '0, '0, 26'h5, 32'h1, "R9");
        step(1, 0, 0, 0, 0, 3'd0, '0, '0, '0, 32'h1, "R9");
        step(1, 1, 0, 0, 0, 3'd4, '0, '0, '0, 32'h0000_0100, "R9");
        step(1, 0, 0, 0, 0, 3'd0, '0, '0, '0, 32'h1, "R2");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    // Watchdog: a hung run is reported as a failed check.
    initial begin
        #(200000 * 5);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule